// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an internal single-beat request bus with valid/ready handshaking and an external 32K x 8 static RAM that has no clock. It turns each accepted request into the correct sequence of active-low chip-select, output-enable and write-strobe levels. It drives a 15-bit address and an 8-bit data bus, which is split into an output value, an input value and a driver enable for the tri-state pad. Each read returns its data together with a one-cycle done pulse.

Nanosecond minimums for the memory's speed grade and the clock period are parameters. The block turns them into whole cycle counts, rounding up, with at least one cycle for each phase. When the transfer direction changes, the block leaves a gap in which nothing drives the data pins, so the memory's output driver and the block's driver never fight.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, mem_ce_no, mem_oe_no and mem_we_no are 1, mem_dq_oe_o is 0, req_ready_o is 1 and rsp_valid_o is 0.
- R2: The strobes use one encoding. Idle has all three high. A write has mem_ce_no=0, mem_we_no=0 and mem_oe_no=1. A read has mem_ce_no=0, mem_oe_no=0 and mem_we_no=1. mem_we_no is never low while mem_ce_no is high, and mem_we_no and mem_oe_no are never low together.
- R3: A write holds mem_we_no low for exactly WP_CYC consecutive cycles. WP_CYC is the largest of the rounded-up write-pulse, data-setup and select-to-end minimums, which is 2 at the defaults. mem_dq_oe_o is 1 and mem_dq_o carries the write data in every one of those cycles.
- R4: After mem_we_no rises, the strobes stay high for REC_CYC = max(1, WC - WP_CYC) cycles and the data stays driven during them. req_ready_o returns WP_CYC+REC_CYC+1 cycles after the accepting edge, which is 4 at the defaults, plus TURN_CYC on a direction change.
- R5: A read holds mem_oe_no low for AA_CYC cycles, which is 2 at the defaults. The block captures mem_dq_i on the edge that ends that interval. rsp_valid_o is high for exactly one cycle with that value on rsp_rdata_o, AA_CYC+1 cycles after the accepting edge, plus TURN_CYC on a direction change.
- R6: mem_dq_oe_o is 0 in every cycle in which mem_oe_no is 0.
- R7: When a request's direction differs from the one before it, TURN_CYC idle cycles (1 at the defaults) come first. In those cycles all strobes are high and the driver is off. The driver is never on in the cycle right after mem_oe_no was low, and mem_oe_no never falls in the cycle right after the driver was on.
- R8: req_ready_o is high only when the block is idle. A request presented only while req_ready_o is low is ignored and leaves the memory untouched.
- R9: While mem_ce_no is low, mem_addr_o equals the accepted address. While mem_we_no is low, mem_dq_o equals the accepted write data.
- R10: rsp_valid_o is raised only for reads, never for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken on this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle read-done pulse |
| rsp_rdata_o | output | 8 | Captured read data |
| mem_addr_o | output | 15 | Address pins |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_i | input | 8 | Data returned from the memory pins |
| mem_dq_oe_o | output | 1 | Tri-state driver enable for the data pins |

## Verification
A state machine stuck in a wrong state or a bad cycle counter shows at the pins within one access. It appears as a strobe low for the wrong number of cycles, as a missing or late done pulse, or as stale read data. A bad direction record shows on the first direction change, either as a missing idle gap or as the driver overlapping the memory's output enable. If the request registers load at the wrong time, the address or data moves while the chip is selected, or a request offered while busy reaches the memory. A bench-side memory model catches this when the address is read back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_WR   = 3'd2,
    ST_WREC = 3'd3,
    ST_RD   = 3'd4
  } ctrl_state_e;

  // ns minimum in ps -> whole cycles, rounded up, at least one
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WP_CYC   = 2,
  parameter int unsigned REC_CYC  = 1,
  parameter int unsigned AA_CYC   = 2,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_write_i,
  output logic ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic ce_no,
  output logic oe_no,
  output logic we_no,
  output logic dq_oe_o
);

  localparam int unsigned MAX_CYC = umax(umax(WP_CYC, REC_CYC), umax(AA_CYC, TURN_CYC));
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] AA_LD   = CNT_W'(AA_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  ctrl_state_e      state_q, state_d;
  logic             dir_q, dir_d;          // direction of current request
  logic             last_dir_q, have_last_q;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    state_d   = state_q;
    dir_d     = dir_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        dir_d    = req_write_i;
        tmr_load = 1'b1;
        if (have_last_q && (last_dir_q != req_write_i)) begin
          state_d = ST_TURN;
          tmr_val = TURN_LD;
        end else if (req_write_i) begin
          state_d = ST_WR;
          tmr_val = WP_LD;
        end else begin
          state_d = ST_RD;
          tmr_val = AA_LD;
        end
      end
      ST_TURN: if (tmr_done) begin
        tmr_load = 1'b1;
        state_d  = dir_q ? ST_WR : ST_RD;
        tmr_val  = dir_q ? WP_LD : AA_LD;
      end
      ST_WR: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
        state_d  = ST_WREC;
      end
      ST_WREC: if (tmr_done) state_d = ST_IDLE;
      ST_RD: if (tmr_done) begin
        capture_o = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      dir_q       <= 1'b0;
      last_dir_q  <= 1'b0;
      have_last_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      if (accept_o) begin
        last_dir_q  <= req_write_i;
        have_last_q <= 1'b1;
      end
    end
  end

  assign ce_no   = !((state_q == ST_WR) || (state_q == ST_RD));
  assign we_no   = (state_q != ST_WR);
  assign oe_no   = (state_q != ST_RD);
  assign dq_oe_o = (state_q == ST_WR) || (state_q == ST_WREC);

  p_strobe_enc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && (ce_no || !oe_no)));

  p_no_fight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !dq_oe_o);

  p_gap_after_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !$past(dq_oe_o));

  p_gap_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> $past(oe_no));

  p_ready_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ce_no && we_no && oe_no && !dq_oe_o));

  p_hold_after_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> dq_oe_o);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              ce_ni,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o  <= '0;
      mem_dq_o    <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      if (accept_i) begin
        mem_addr_o <= req_addr_i;
        mem_dq_o   <= req_wdata_i;
      end
      if (capture_i) rsp_rdata_o <= mem_dq_i;
      rsp_valid_o <= capture_i;
    end
  end

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && $past(!ce_ni)) |-> $stable(mem_addr_o));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_WC_PS       = 12000,
  parameter int unsigned T_WP_PS       = 10000,
  parameter int unsigned T_CW_PS       = 10000,
  parameter int unsigned T_DW_PS       = 7000,
  parameter int unsigned T_AA_PS       = 12000,
  parameter int unsigned T_OE_PS       = 6000,
  parameter int unsigned T_FLOAT_PS    = 6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);

  localparam int unsigned WC_CYC   = ps_to_cyc(T_WC_PS, CLK_PERIOD_PS);
  localparam int unsigned WP_CYC   = umax(ps_to_cyc(T_WP_PS, CLK_PERIOD_PS),
                                          umax(ps_to_cyc(T_CW_PS, CLK_PERIOD_PS),
                                               ps_to_cyc(T_DW_PS, CLK_PERIOD_PS)));
  localparam int unsigned REC_CYC  = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned AA_CYC   = umax(ps_to_cyc(T_AA_PS, CLK_PERIOD_PS),
                                          ps_to_cyc(T_OE_PS, CLK_PERIOD_PS));
  localparam int unsigned TURN_CYC = ps_to_cyc(T_FLOAT_PS, CLK_PERIOD_PS);

  logic accept, capture;

  sram_ctrl_fsm #(
    .WP_CYC   (WP_CYC),
    .REC_CYC  (REC_CYC),
    .AA_CYC   (AA_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .ce_no       (mem_ce_no),
    .oe_no       (mem_oe_no),
    .we_no       (mem_we_no),
    .dq_oe_o     (mem_dq_oe_o)
  );

  sram_dq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .ce_ni       (mem_ce_no),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  p_read_only_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!mem_oe_no));

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int EXP_WE_LOW = 2;   // R3
  localparam int EXP_WR_LAT = 4;   // R4
  localparam int EXP_RD_LAT = 3;   // R5
  localparam int EXP_TURN   = 1;   // R7

  typedef struct packed {
    logic        wr;
    logic [14:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 15'h0012, 8'hA5},
    '{1'b1, 15'h7F34, 8'h3C},
    '{1'b0, 15'h0012, 8'hA5},
    '{1'b0, 15'h7F34, 8'h3C},
    '{1'b1, 15'h0012, 8'h5A},
    '{1'b1, 15'h00FF, 8'h00},
    '{1'b0, 15'h0012, 8'h5A},
    '{1'b0, 15'h00FF, 8'h00},
    '{1'b1, 15'h4001, 8'hFF},
    '{1'b0, 15'h4001, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  int checks = 0, failures = 0;
  int viol_r2 = 0, viol_r3 = 0, viol_r6 = 0, viol_r7 = 0, viol_r9 = 0, viol_r10 = 0;
  bit done_flag = 0;
  logic [14:0] cur_addr = '0;
  logic [7:0]  cur_data = '0;
  logic        prev_dq_oe = 1'b0, prev_oe_n = 1'b1;
  logic        have_last = 1'b0, last_wr = 1'b0;
  logic [7:0]  mem [256];

  always #4 clk = ~clk;

  sram_async_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  assign dq_i = (!ce_n && !oe_n && we_n) ? mem[mem_addr[7:0]] : 8'hEE;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and pin monitor
  always @(negedge clk) if (rst_n) begin
    if (!we_n && (ce_n || !oe_n)) viol_r2++;
    if (!oe_n && dq_oe) viol_r6++;
    if ((!oe_n && prev_dq_oe) || (dq_oe && !prev_oe_n)) viol_r7++;
    if (!ce_n && mem_addr != cur_addr) viol_r9++;
    if (!we_n && dq_o != cur_data) viol_r9++;
    if (!ce_n && !we_n) begin
      if (!dq_oe) viol_r3++;
      mem[mem_addr[7:0]] = dq_o;
    end
    prev_dq_oe = dq_oe;
    prev_oe_n  = oe_n;
  end else begin
    prev_dq_oe = 1'b0;
    prev_oe_n  = 1'b1;
  end

  task automatic do_req(input logic wr, input logic [14:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat, output int welow,
                        output bit turned);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    turned = have_last && (last_wr != wr);
    have_last = 1'b1; last_wr = wr;
    cur_addr = a; cur_data = d;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; welow = 0; rd = '0;
    if (wr) begin
      while (!req_ready) begin
        if (!we_n) welow++;
        if (rsp_valid) viol_r10++;
        @(negedge clk); lat++;
      end
      if (rsp_valid) viol_r10++;
    end else begin
      while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
      @(negedge clk);
      check(!rsp_valid, "R5 done pulse width", rsp_valid, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int lat, welow;
    bit turned;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({ce_n, oe_n, we_n, dq_oe, req_ready, rsp_valid} == 6'b111010,
          "R1 reset pins", {ce_n, oe_n, we_n, dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    check({ce_n, oe_n, we_n, dq_oe, req_ready, rsp_valid} == 6'b111010,
          "R1 after release", {ce_n, oe_n, we_n, dq_oe, req_ready, rsp_valid}, 6'b111010);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_req(VECS[v].wr, VECS[v].addr, VECS[v].data, rd, lat, welow, turned);
      if (VECS[v].wr) begin
        check(welow == EXP_WE_LOW, "R3 write strobe cycles", welow, EXP_WE_LOW);
        check(lat == EXP_WR_LAT + (turned ? EXP_TURN : 0), "R4 write cycle length",
              lat, EXP_WR_LAT + (turned ? EXP_TURN : 0));
      end else begin
        check(rd == VECS[v].data, "R5 read data", rd, VECS[v].data);
        check(lat == EXP_RD_LAT + (turned ? EXP_TURN : 0), "R5/R7 read latency",
              lat, EXP_RD_LAT + (turned ? EXP_TURN : 0));
      end
    end

    // R8: request offered only while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr = 15'h0060; cur_data = 8'h11;
    have_last = 1'b1; last_wr = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0060; req_wdata = 8'h11;
    @(posedge clk); @(negedge clk);
    req_addr = 15'h0061; req_wdata = 8'h99;     // stays valid while busy
    check(!req_ready, "R8 busy ready low", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_addr == 15'h0060, "R8 address unchanged while busy", mem_addr, 15'h0060);
    while (!req_ready) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check(ce_n && we_n, "R8 no late accept", {ce_n, we_n}, 2'b11);
    end
    do_req(1'b0, 15'h0061, 8'h00, rd, lat, welow, turned);
    check(rd == 8'h00, "R8 ignored write left memory", rd, 8'h00);
    do_req(1'b0, 15'h0060, 8'h11, rd, lat, welow, turned);
    check(rd == 8'h11, "R8 accepted write stored", rd, 8'h11);

    // R1: reset in the middle of a read
    @(negedge clk);
    cur_addr = 15'h0012; cur_data = 8'h00;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0012;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check({ce_n, oe_n, we_n, dq_oe, req_ready} == 5'b11101, "R1 mid-read reset",
          {ce_n, oe_n, we_n, dq_oe, req_ready}, 5'b11101);
    @(negedge clk);
    rst_n = 1'b1;
    have_last = 1'b0;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R1 no done after reset", rsp_valid, 0);

    // write right after reset: no turnaround
    do_req(1'b1, 15'h0012, 8'hC3, rd, lat, welow, turned);
    check(lat == EXP_WR_LAT, "R7 no gap after reset", lat, EXP_WR_LAT);
    do_req(1'b0, 15'h0012, 8'hC3, rd, lat, welow, turned);
    check(rd == 8'hC3 && lat == EXP_RD_LAT + EXP_TURN, "R7 write-to-read gap", lat,
          EXP_RD_LAT + EXP_TURN);

    repeat (2) @(negedge clk);
    check(viol_r2 == 0, "R2 strobe encoding", viol_r2, 0);
    check(viol_r3 == 0, "R3 data driven during strobe", viol_r3, 0);
    check(viol_r6 == 0, "R6 driver off during read", viol_r6, 0);
    check(viol_r7 == 0, "R7 turnaround gap", viol_r7, 0);
    check(viol_r9 == 0, "R9 pins stable", viol_r9, 0);
    check(viol_r10 == 0, "R10 no done on write", viol_r10, 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule